// File: doc/BRIEF.md
# Banked Register File with Exchange

This block is the register storage of an 8-bit processor core. It holds the accumulator and flags byte, the six general bytes that combine into three 16-bit pairs, a full alternate copy of those eight bytes, three 16-bit address registers (stack pointer and two index registers), an 8-bit vector-base register and an 8-bit refresh counter. Decode logic drives register selects and write strobes, and the block answers on two byte read ports and one pair read port. It accepts one byte write and one pair write per cycle.

Switching between the main and alternate sets is done by flipping select bits, not by moving data. The accumulator/flags group and the three-pair group each have their own select bit. Each bank of the three-pair group also keeps a bit that records whether its second and third pairs are currently swapped. Every exchange therefore takes one cycle and leaves storage untouched. The stack pointer can be copied from one of three sources in a single cycle. The low seven bits of the refresh counter advance on each fetch strobe.

Top module: `regbank_xchg`

## Requirements
- R1: Byte selects are 0=A, 1=F, 2=B, 3=C, 4=D, 5=E, 6=H, 7=L, 8=vector base, 9=refresh. A byte write is visible on both read ports from the next cycle. Selects 10 to 15 read as zero, and writes to them change nothing.
- R2: Pair selects are 0=BC, 1=DE, 2=HL, 3=SP, 4=IX, 5=IY, and selects 6 and 7 read as zero. In BC, DE and HL the first-named byte is bits 15:8. When a byte write and a pair write touch the same byte in one cycle, the byte write wins.
- R3: The exchange-all strobe swaps BC, DE and HL with their alternate copies. It leaves A and F unchanged.
- R4: The accumulator-exchange strobe swaps A and F with their alternate copies. It leaves every pair unchanged.
- R5: The DE/HL exchange strobe swaps DE and HL in the active bank only. The inactive bank keeps its own order.
- R6: With the SP-load enable high, SP takes the current HL, IX or IY for source codes 0, 1 or 2 respectively. Source code 3 leaves SP unchanged. An SP load takes priority over a pair write to SP in the same cycle.
- R7: Each fetch strobe increments refresh bits 6:0, wrapping from 0x7F to 0x00, while bit 7 holds its written value. A byte write to the refresh register in the same cycle takes priority over the increment.
- R8: Reset (active low) clears every register in both banks and both bank-select bits.
- R9: A write issued in the same cycle as an exchange lands in the bank, and in the DE/HL order, that was active before that exchange.
- R10: Exchange strobes raised together each take effect in that cycle. A DE/HL exchange raised with exchange-all acts on the bank that was active before the switch. Repeating any exchange restores the previous view.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rdSelA | input | 4 | Byte select, read port A |
| rdDataA | output | 8 | Byte read data A (combinational) |
| rdSelB | input | 4 | Byte select, read port B |
| rdDataB | output | 8 | Byte read data B (combinational) |
| wrEn | input | 1 | Byte write enable |
| wrSel | input | 4 | Byte write select |
| wrData | input | 8 | Byte write data |
| pairRdSel | input | 3 | Pair read select |
| pairRdData | output | 16 | Pair read data (combinational) |
| pairWrEn | input | 1 | Pair write enable |
| pairWrSel | input | 3 | Pair write select |
| pairWrData | input | 16 | Pair write data |
| xchgAll | input | 1 | Swap BC/DE/HL with the alternate bank |
| xchgAf | input | 1 | Swap A/F with the alternate copies |
| xchgDeHl | input | 1 | Swap DE and HL in the active bank |
| spLoadEn | input | 1 | Load SP from the selected source |
| spLoadSrc | input | 2 | SP source: 0 HL, 1 IX, 2 IY, 3 none |
| fetchStb | input | 1 | Instruction fetch strobe (refresh increment) |

## Verification
The bench targets the simultaneous cases. A write issued during an exchange lands in the bank that was active before it; a design that applied the new select first would put the byte into the wrong copy, and the error shows only after swapping back. A DE/HL swap raised together with exchange-all must reorder the bank being switched away from. It also must not disturb the order in the other bank, so a single shared swap bit would expose the shadow pairs reversed. The bench also covers refresh wrap at 0x7F with bit 7 set, byte writes that override pair writes, SP source code 3, and unused selects. A long mixed sweep compares all registers every cycle against a model that really moves the data on each exchange.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
  localparam int BYTE_W = 8;
  localparam int PAIR_W = 2 * BYTE_W;
  localparam int SEL_W  = 4;
  localparam int PSEL_W = 3;
  localparam int NBYTE  = 10;
  localparam int NPAIR  = 6;
  localparam int SRC_W  = 2;

  localparam logic [SEL_W-1:0] SEL_A = 4'd0;
  localparam logic [SEL_W-1:0] SEL_F = 4'd1;
  localparam logic [SEL_W-1:0] SEL_B = 4'd2;
  localparam logic [SEL_W-1:0] SEL_C = 4'd3;
  localparam logic [SEL_W-1:0] SEL_D = 4'd4;
  localparam logic [SEL_W-1:0] SEL_E = 4'd5;
  localparam logic [SEL_W-1:0] SEL_H = 4'd6;
  localparam logic [SEL_W-1:0] SEL_L = 4'd7;
  localparam logic [SEL_W-1:0] SEL_I = 4'd8;
  localparam logic [SEL_W-1:0] SEL_R = 4'd9;

  localparam logic [PSEL_W-1:0] PR_BC = 3'd0;
  localparam logic [PSEL_W-1:0] PR_DE = 3'd1;
  localparam logic [PSEL_W-1:0] PR_HL = 3'd2;
  localparam logic [PSEL_W-1:0] PR_SP = 3'd3;
  localparam logic [PSEL_W-1:0] PR_IX = 3'd4;
  localparam logic [PSEL_W-1:0] PR_IY = 3'd5;

  localparam logic [SRC_W-1:0] SRC_HL   = 2'd0;
  localparam logic [SRC_W-1:0] SRC_IX   = 2'd1;
  localparam logic [SRC_W-1:0] SRC_IY   = 2'd2;
  localparam logic [SRC_W-1:0] SRC_NONE = 2'd3;

  typedef struct packed {
    logic             afBank;
    logic             grpBank;
    logic             deSlot;
    logic [NBYTE-1:0] byteWe;
    logic [NPAIR-1:0] pairWe;
    logic             spLoad;
    logic [SRC_W-1:0] spSrc;
    logic             rInc;
  } rb_ctl_t;
endpackage

// File: rtl/regbank_ctrl.sv
module regbank_ctrl
  import regbank_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [SEL_W-1:0]  wrSel,
  input  logic              pairWrEn,
  input  logic [PSEL_W-1:0] pairWrSel,
  input  logic              xchgAll,
  input  logic              xchgAf,
  input  logic              xchgDeHl,
  input  logic              spLoadEn,
  input  logic [SRC_W-1:0]  spLoadSrc,
  input  logic              fetchStb,
  output rb_ctl_t           ctl
);
  logic       afBankQ;
  logic       grpBankQ;
  logic [1:0] swapQ;
  logic [NBYTE-1:0] byteWe;
  logic [NPAIR-1:0] pairWe;

  // bank selection: toggles only, data never moves
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      afBankQ  <= 1'b0;
      grpBankQ <= 1'b0;
      swapQ    <= '0;
    end else begin
      if (xchgAf)   afBankQ  <= ~afBankQ;
      if (xchgAll)  grpBankQ <= ~grpBankQ;
      if (xchgDeHl) swapQ[grpBankQ] <= ~swapQ[grpBankQ];
    end
  end

  for (genvar k = 0; k < NBYTE; k++) begin : g_byteWe
    assign byteWe[k] = wrEn && (wrSel == SEL_W'(k));
  end

  for (genvar k = 0; k < NPAIR; k++) begin : g_pairWe
    assign pairWe[k] = pairWrEn && (pairWrSel == PSEL_W'(k));
  end

  always_comb begin
    ctl.afBank  = afBankQ;
    ctl.grpBank = grpBankQ;
    ctl.deSlot  = swapQ[grpBankQ];
    ctl.byteWe  = byteWe;
    ctl.pairWe  = pairWe;
    ctl.spLoad  = spLoadEn && (spLoadSrc != SRC_NONE);
    ctl.spSrc   = spLoadSrc;
    ctl.rInc    = fetchStb;
  end
endmodule

// File: rtl/regbank_dp.sv
module regbank_dp
  import regbank_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  rb_ctl_t           ctl,
  input  logic [BYTE_W-1:0] wrData,
  input  logic [PAIR_W-1:0] pairWrData,
  input  logic [SEL_W-1:0]  rdSelA,
  input  logic [SEL_W-1:0]  rdSelB,
  input  logic [PSEL_W-1:0] pairRdSel,
  output logic [BYTE_W-1:0] rdDataA,
  output logic [BYTE_W-1:0] rdDataB,
  output logic [PAIR_W-1:0] pairRdData
);
  localparam int CNT_W = BYTE_W - 1;

  logic [1:0][BYTE_W-1:0]      accQ, flgQ;
  logic [1:0][PAIR_W-1:0]      bcQ;
  logic [1:0][1:0][PAIR_W-1:0] slotQ;
  logic [PAIR_W-1:0] spQ, ixQ, iyQ;
  logic [BYTE_W-1:0] iQ, rQ;

  logic              ds;
  logic [BYTE_W-1:0] curA, curF, nxtA, nxtF, nxtI, nxtR;
  logic [PAIR_W-1:0] curBC, curDE, curHL, nxtBC, nxtDE, nxtHL;
  logic [PAIR_W-1:0] spSrcVal, nxtSP, nxtIX, nxtIY;

  function automatic logic [PAIR_W-1:0] mergePair(
    input logic [PAIR_W-1:0] cur, input logic pwe,
    input logic hiWe, input logic loWe,
    input logic [PAIR_W-1:0] pdat, input logic [BYTE_W-1:0] bdat);
    logic [PAIR_W-1:0] v;
    v = pwe ? pdat : cur;
    if (hiWe) v[PAIR_W-1:BYTE_W] = bdat;
    if (loWe) v[BYTE_W-1:0] = bdat;
    return v;
  endfunction

  assign ds    = ctl.deSlot;
  assign curA  = accQ[ctl.afBank];
  assign curF  = flgQ[ctl.afBank];
  assign curBC = bcQ[ctl.grpBank];
  assign curDE = slotQ[ctl.grpBank][ds];
  assign curHL = slotQ[ctl.grpBank][!ds];

  always_comb begin
    nxtA  = ctl.byteWe[SEL_A] ? wrData : curA;
    nxtF  = ctl.byteWe[SEL_F] ? wrData : curF;
    nxtBC = mergePair(curBC, ctl.pairWe[PR_BC], ctl.byteWe[SEL_B], ctl.byteWe[SEL_C], pairWrData, wrData);
    nxtDE = mergePair(curDE, ctl.pairWe[PR_DE], ctl.byteWe[SEL_D], ctl.byteWe[SEL_E], pairWrData, wrData);
    nxtHL = mergePair(curHL, ctl.pairWe[PR_HL], ctl.byteWe[SEL_H], ctl.byteWe[SEL_L], pairWrData, wrData);
    case (ctl.spSrc)
      SRC_HL:  spSrcVal = curHL;
      SRC_IX:  spSrcVal = ixQ;
      default: spSrcVal = iyQ;
    endcase
    if (ctl.spLoad)              nxtSP = spSrcVal;
    else if (ctl.pairWe[PR_SP])  nxtSP = pairWrData;
    else                         nxtSP = spQ;
    nxtIX = ctl.pairWe[PR_IX] ? pairWrData : ixQ;
    nxtIY = ctl.pairWe[PR_IY] ? pairWrData : iyQ;
    nxtI  = ctl.byteWe[SEL_I] ? wrData : iQ;
    if (ctl.byteWe[SEL_R])  nxtR = wrData;
    else if (ctl.rInc)      nxtR = {rQ[BYTE_W-1], rQ[CNT_W-1:0] + CNT_W'(1)};
    else                    nxtR = rQ;
  end

  // writes land in the bank and slot order selected before this edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accQ  <= '0;
      flgQ  <= '0;
      bcQ   <= '0;
      slotQ <= '0;
      spQ   <= '0;
      ixQ   <= '0;
      iyQ   <= '0;
      iQ    <= '0;
      rQ    <= '0;
    end else begin
      accQ[ctl.afBank]         <= nxtA;
      flgQ[ctl.afBank]         <= nxtF;
      bcQ[ctl.grpBank]         <= nxtBC;
      slotQ[ctl.grpBank][ds]   <= nxtDE;
      slotQ[ctl.grpBank][!ds]  <= nxtHL;
      spQ <= nxtSP;
      ixQ <= nxtIX;
      iyQ <= nxtIY;
      iQ  <= nxtI;
      rQ  <= nxtR;
    end
  end

  function automatic logic [BYTE_W-1:0] byteView(input logic [SEL_W-1:0] sel);
    case (sel)
      SEL_A:   return curA;
      SEL_F:   return curF;
      SEL_B:   return curBC[PAIR_W-1:BYTE_W];
      SEL_C:   return curBC[BYTE_W-1:0];
      SEL_D:   return curDE[PAIR_W-1:BYTE_W];
      SEL_E:   return curDE[BYTE_W-1:0];
      SEL_H:   return curHL[PAIR_W-1:BYTE_W];
      SEL_L:   return curHL[BYTE_W-1:0];
      SEL_I:   return iQ;
      SEL_R:   return rQ;
      default: return '0;
    endcase
  endfunction

  assign rdDataA = byteView(rdSelA);
  assign rdDataB = byteView(rdSelB);

  always_comb begin
    case (pairRdSel)
      PR_BC:   pairRdData = curBC;
      PR_DE:   pairRdData = curDE;
      PR_HL:   pairRdData = curHL;
      PR_SP:   pairRdData = spQ;
      PR_IX:   pairRdData = ixQ;
      PR_IY:   pairRdData = iyQ;
      default: pairRdData = '0;
    endcase
  end
endmodule

// File: rtl/regbank_xchg.sv
module regbank_xchg
  import regbank_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [SEL_W-1:0]  rdSelA,
  output logic [BYTE_W-1:0] rdDataA,
  input  logic [SEL_W-1:0]  rdSelB,
  output logic [BYTE_W-1:0] rdDataB,
  input  logic              wrEn,
  input  logic [SEL_W-1:0]  wrSel,
  input  logic [BYTE_W-1:0] wrData,
  input  logic [PSEL_W-1:0] pairRdSel,
  output logic [PAIR_W-1:0] pairRdData,
  input  logic              pairWrEn,
  input  logic [PSEL_W-1:0] pairWrSel,
  input  logic [PAIR_W-1:0] pairWrData,
  input  logic              xchgAll,
  input  logic              xchgAf,
  input  logic              xchgDeHl,
  input  logic              spLoadEn,
  input  logic [SRC_W-1:0]  spLoadSrc,
  input  logic              fetchStb
);
  rb_ctl_t ctl;

  regbank_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .wrEn(wrEn), .wrSel(wrSel),
    .pairWrEn(pairWrEn), .pairWrSel(pairWrSel),
    .xchgAll(xchgAll), .xchgAf(xchgAf), .xchgDeHl(xchgDeHl),
    .spLoadEn(spLoadEn), .spLoadSrc(spLoadSrc),
    .fetchStb(fetchStb),
    .ctl(ctl)
  );

  regbank_dp u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .wrData(wrData), .pairWrData(pairWrData),
    .rdSelA(rdSelA), .rdSelB(rdSelB), .pairRdSel(pairRdSel),
    .rdDataA(rdDataA), .rdDataB(rdDataB), .pairRdData(pairRdData)
  );
endmodule

// File: rtl/regbank_xchg_chk.sv
module regbank_xchg_chk (
  input logic        clk,
  input logic        rstN,
  input logic [3:0]  rdSelA,
  input logic [7:0]  rdDataA,
  input logic [3:0]  rdSelB,
  input logic [7:0]  rdDataB,
  input logic        wrEn,
  input logic [3:0]  wrSel,
  input logic [7:0]  wrData,
  input logic [2:0]  pairRdSel,
  input logic [15:0] pairRdData,
  input logic        pairWrEn,
  input logic        xchgAll,
  input logic        xchgAf,
  input logic        xchgDeHl,
  input logic        spLoadEn,
  input logic        fetchStb
);
  logic quiet;
  assign quiet = !wrEn && !pairWrEn && !spLoadEn;

  // R1: a written byte reads back on the next cycle
  a_r1_byte_write: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrSel <= 4'd9 && !xchgAll && !xchgAf && !xchgDeHl && rdSelA == wrSel)
    |=> (rdSelA != $past(wrSel)) || (rdDataA == $past(wrData)))
    else $error("a_r1_byte_write");

  // R3: exchange-all leaves A and F alone
  a_r3_all_keeps_af: assert property (@(posedge clk) disable iff (!rstN)
    (quiet && xchgAll && !xchgAf && rdSelA <= 4'd1)
    |=> (rdSelA != $past(rdSelA)) || (rdDataA == $past(rdDataA)))
    else $error("a_r3_all_keeps_af");

  // R4: accumulator exchange leaves every pair alone
  a_r4_af_keeps_pairs: assert property (@(posedge clk) disable iff (!rstN)
    (quiet && xchgAf && !xchgAll && !xchgDeHl)
    |=> (pairRdSel != $past(pairRdSel)) || (pairRdData == $past(pairRdData)))
    else $error("a_r4_af_keeps_pairs");

  // R5: DE/HL exchange moves D to H and H to D
  a_r5_dehl_swap: assert property (@(posedge clk) disable iff (!rstN)
    (quiet && xchgDeHl && !xchgAll && rdSelA == 4'd4 && rdSelB == 4'd6)
    |=> (rdSelA != 4'd4 || rdSelB != 4'd6) ||
        (rdDataA == $past(rdDataB) && rdDataB == $past(rdDataA)))
    else $error("a_r5_dehl_swap");

  // R7: refresh counts in bits 6:0 and holds bit 7
  a_r7_refresh_count: assert property (@(posedge clk) disable iff (!rstN)
    (fetchStb && !(wrEn && wrSel == 4'd9) && rdSelB == 4'd9)
    |=> (rdSelB != 4'd9) ||
        (rdDataB[6:0] == $past(rdDataB[6:0]) + 7'd1 && rdDataB[7] == $past(rdDataB[7])))
    else $error("a_r7_refresh_count");

  // R8: everything reads zero while reset is held
  always @(negedge clk) begin
    if (!rstN) begin
      a_r8_reset_clear: assert (rdDataA == 8'd0 && rdDataB == 8'd0 && pairRdData == 16'd0)
        else $error("a_r8_reset_clear");
    end
  end
endmodule

bind regbank_xchg regbank_xchg_chk u_chk (.*);

// File: tb/regbank_xchg_test.sv
`timescale 1ns/1ps
module regbank_xchg_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  rdSelA = '0, rdSelB = '0, wrSel = '0;
  logic [7:0]  rdDataA, rdDataB, wrData = '0;
  logic [2:0]  pairRdSel = '0, pairWrSel = '0;
  logic [15:0] pairRdData, pairWrData = '0;
  logic        wrEn = 0, pairWrEn = 0, xchgAll = 0, xchgAf = 0, xchgDeHl = 0;
  logic        spLoadEn = 0, fetchStb = 0;
  logic [1:0]  spLoadSrc = '0;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  regbank_xchg uut (.*);

  // reference model: exchanges physically move values
  logic [7:0]  mA, mF, sA, sF, mI, mR;
  logic [15:0] mBC, mDE, mHL, sBC, sDE, sHL, mSP, mIX, mIY;

  task automatic modelReset();
    mA = 0; mF = 0; sA = 0; sF = 0; mI = 0; mR = 0;
    mBC = 0; mDE = 0; mHL = 0; sBC = 0; sDE = 0; sHL = 0;
    mSP = 0; mIX = 0; mIY = 0;
  endtask

  function automatic logic [7:0] expByte(input logic [3:0] s);
    case (s)
      4'd0: return mA;   4'd1: return mF;
      4'd2: return mBC[15:8]; 4'd3: return mBC[7:0];
      4'd4: return mDE[15:8]; 4'd5: return mDE[7:0];
      4'd6: return mHL[15:8]; 4'd7: return mHL[7:0];
      4'd8: return mI;   4'd9: return mR;
      default: return 8'd0;
    endcase
  endfunction

  function automatic logic [15:0] expPair(input logic [2:0] s);
    case (s)
      3'd0: return mBC; 3'd1: return mDE; 3'd2: return mHL;
      3'd3: return mSP; 3'd4: return mIX; 3'd5: return mIY;
      default: return 16'd0;
    endcase
  endfunction

  task automatic modelStep();
    logic [15:0] oHL, oIX, oIY, t;
    logic [7:0]  tb8;
    oHL = mHL; oIX = mIX; oIY = mIY;
    if (fetchStb) mR = (mR & 8'h80) | ((mR + 8'd1) & 8'h7F);
    if (pairWrEn) case (pairWrSel)
      3'd0: mBC = pairWrData; 3'd1: mDE = pairWrData; 3'd2: mHL = pairWrData;
      3'd3: mSP = pairWrData; 3'd4: mIX = pairWrData; 3'd5: mIY = pairWrData;
      default: ;
    endcase
    if (wrEn) case (wrSel)
      4'd0: mA = wrData; 4'd1: mF = wrData;
      4'd2: mBC[15:8] = wrData; 4'd3: mBC[7:0] = wrData;
      4'd4: mDE[15:8] = wrData; 4'd5: mDE[7:0] = wrData;
      4'd6: mHL[15:8] = wrData; 4'd7: mHL[7:0] = wrData;
      4'd8: mI = wrData; 4'd9: mR = wrData;
      default: ;
    endcase
    if (spLoadEn) case (spLoadSrc)
      2'd0: mSP = oHL; 2'd1: mSP = oIX; 2'd2: mSP = oIY;
      default: ;
    endcase
    if (xchgDeHl) begin t = mDE; mDE = mHL; mHL = t; end
    if (xchgAll) begin
      t = mBC; mBC = sBC; sBC = t;
      t = mDE; mDE = sDE; sDE = t;
      t = mHL; mHL = sHL; sHL = t;
    end
    if (xchgAf) begin
      tb8 = mA; mA = sA; sA = tb8;
      tb8 = mF; mF = sF; sF = tb8;
    end
  endtask

  task automatic clearIn();
    wrEn = 0; pairWrEn = 0; xchgAll = 0; xchgAf = 0; xchgDeHl = 0;
    spLoadEn = 0; fetchStb = 0; spLoadSrc = 0;
  endtask

  // inputs are already set; one clock applies them
  task automatic cycle();
    @(posedge clk);
    modelStep();
    @(negedge clk);
    clearIn();
  endtask

  task automatic checkAll(input string tag);
    for (int s = 0; s < 16; s++) begin
      rdSelA = 4'(s); rdSelB = 4'(15 - s);
      #0.05;
      checks++;
      if (rdDataA !== expByte(4'(s))) begin
        fails++;
        $display("FAIL %s byte sel %0d port A: got %h expected %h", tag, s, rdDataA, expByte(4'(s)));
      end
      checks++;
      if (rdDataB !== expByte(4'(15 - s))) begin
        fails++;
        $display("FAIL %s byte sel %0d port B: got %h expected %h", tag, 15 - s, rdDataB, expByte(4'(15 - s)));
      end
    end
    for (int p = 0; p < 8; p++) begin
      pairRdSel = 3'(p);
      #0.05;
      checks++;
      if (pairRdData !== expPair(3'(p))) begin
        fails++;
        $display("FAIL %s pair sel %0d: got %h expected %h", tag, p, pairRdData, expPair(3'(p)));
      end
    end
  endtask

  task automatic byteWr(input logic [3:0] s, input logic [7:0] d);
    wrEn = 1; wrSel = s; wrData = d;
  endtask

  task automatic pairWr(input logic [2:0] s, input logic [15:0] d);
    pairWrEn = 1; pairWrSel = s; pairWrData = d;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    modelReset();
    repeat (3) @(negedge clk);
    checkAll("R8");
    rstN = 1'b1;
    @(negedge clk);

    // R1: every byte register, plus an unused select
    for (int s = 0; s < 10; s++) begin
      byteWr(4'(s), 8'(8'h11 * (s + 1) + 3));
      cycle();
    end
    checkAll("R1");
    byteWr(4'd12, 8'hEE); cycle();
    checkAll("R1");

    // R2: pairs, and byte write over pair write
    for (int p = 0; p < 6; p++) begin
      pairWr(3'(p), 16'(16'h1357 * (p + 1)));
      cycle();
    end
    checkAll("R2");
    pairWr(3'd0, 16'hABCD); byteWr(4'd3, 8'h5A); cycle();
    checkAll("R2");
    pairWr(3'd2, 16'h1234); byteWr(4'd6, 8'h99); cycle();
    checkAll("R2");

    // R3: exchange-all into a zeroed shadow, fill, swap back
    xchgAll = 1; cycle();
    checkAll("R3");
    pairWr(3'd0, 16'hB0C0); cycle();
    pairWr(3'd1, 16'hD0E0); cycle();
    pairWr(3'd2, 16'h4050); cycle();
    xchgAll = 1; cycle();
    checkAll("R3");

    // R4: accumulator exchange
    xchgAf = 1; cycle();
    checkAll("R4");
    byteWr(4'd0, 8'hA5); cycle();
    byteWr(4'd1, 8'hF5); cycle();
    xchgAf = 1; cycle();
    checkAll("R4");
    xchgAf = 1; cycle();
    checkAll("R4");

    // R5: DE/HL swap touches only the active bank
    xchgDeHl = 1; cycle();
    checkAll("R5");
    xchgAll = 1; cycle();
    checkAll("R5");
    xchgDeHl = 1; cycle();
    checkAll("R5");
    xchgAll = 1; cycle();
    checkAll("R5");

    // R6: SP sources, code 3 ignored, priority over pair write
    for (int k = 0; k < 4; k++) begin
      pairWr(3'd3, 16'h0F0F + 16'(k)); cycle();
      spLoadEn = 1; spLoadSrc = 2'(k); cycle();
      checkAll("R6");
    end
    spLoadEn = 1; spLoadSrc = 2'd1; pairWr(3'd3, 16'hDEAD); cycle();
    checkAll("R6");

    // R7: refresh wrap with bit 7 held, write beats increment
    byteWr(4'd9, 8'hFF); cycle();
    fetchStb = 1; cycle();
    checkAll("R7");
    byteWr(4'd9, 8'h7E); cycle();
    fetchStb = 1; cycle();
    fetchStb = 1; cycle();
    checkAll("R7");
    fetchStb = 1; byteWr(4'd9, 8'h42); cycle();
    checkAll("R7");

    // R9: writes during exchanges land in the prior view
    xchgAll = 1; byteWr(4'd2, 8'h77); cycle();
    checkAll("R9");
    xchgAf = 1; byteWr(4'd0, 8'h3C); cycle();
    checkAll("R9");
    xchgDeHl = 1; pairWr(3'd1, 16'h600D); cycle();
    checkAll("R9");
    xchgAll = 1; cycle();
    checkAll("R9");

    // R10: all strobes together, then again
    xchgAll = 1; xchgAf = 1; xchgDeHl = 1; cycle();
    checkAll("R10");
    xchgAll = 1; xchgAf = 1; xchgDeHl = 1; cycle();
    checkAll("R10");

    // mixed sweep over every strobe combination and select
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom;
      wrEn = r[0]; wrSel = 4'($urandom % 16); wrData = 8'($urandom);
      pairWrEn = r[1] & r[2]; pairWrSel = 3'($urandom % 8); pairWrData = 16'($urandom);
      xchgAll = r[3]; xchgAf = r[4]; xchgDeHl = r[5];
      spLoadEn = r[6] & r[7]; spLoadSrc = r[9:8]; fetchStb = r[10];
      cycle();
      checkAll("R10");
    end

    // R8: reset again after activity, shadows included
    rstN = 1'b0;
    modelReset();
    @(negedge clk);
    checkAll("R8");
    rstN = 1'b1;
    @(negedge clk);
    xchgAll = 1; xchgAf = 1; cycle();
    checkAll("R8");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule